// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Character Timeout

This block buffers incoming serial bytes for a host in a 16550-style serial port. Received bytes enter a 16-entry circular queue. The host drains the queue with a read strobe. An 8-bit control register sets the queue's behaviour: it enables queued mode, flushes the queues and selects a trigger level of 1, 4, 8 or 14 bytes. The block raises a flag when the fill count reaches that trigger level.

The block also runs an idle watchdog that counts character-time ticks. If four character times pass with data waiting and no byte arriving or leaving, a timeout becomes pending. The host can then collect a short tail of data that never reaches the trigger level.

When queued mode is off, a single holding register takes the place of the queue. The receive-break indication is also kept here, because it clears together with data-ready.

Top module: `rx_fifo_ctl`

## Requirements
- R1: After reset the control register reads 0x00 (queued mode off). The count, data-ready, trigger, break, timeout, overrun and transmit-flush outputs are all 0.
- R2: In queued mode (control bit 0 = 1), bytes are read back in arrival order. Up to 16 bytes are held, and storage positions wrap around after the 16th.
- R3: A byte that arrives while 16 bytes are held is dropped and the count stays at 16. `overrun` is high for one cycle in the cycle after the arrival.
- R4: In queued mode, a read of an empty queue returns 0x00 and leaves the count at 0.
- R5: Control bits 7:6 select the trigger level: 00 selects 1 byte, 01 selects 4, 10 selects 8 and 11 selects 14. In queued mode, `trig_hit` is high while the count is at least that level.
- R6: A control write whose value equals the current register contents has no effect. Otherwise only bits 7, 6, 3 and 0 of the written value are kept (mask 0xC9).
- R7: A control write that changes the register and has bit 1 set empties the receive queue and clears data-ready, break and any pending timeout. Bit 2 set makes `tx_flush` pulse for one cycle and does not change the receive queue.
- R8: A control write that changes bit 0 performs both flushes of R7, even when bits 1 and 2 are written as 0.
- R9: Each accepted byte, and each read that leaves data in the queue, restarts a count of character ticks. On the 4th tick after a restart, `tmo_pend` rises if the queue still holds data. It stays low if the queue is empty.
- R10: In queued mode, a host read clears `tmo_pend`.
- R11: A break strobe stores a 0x00 byte and sets `brk_flag` and data-ready. The read that empties the queue (or the holding register) clears both.
- R12: With queued mode off, each received byte overwrites the holding register and sets data-ready, and the count reads 1. A read returns the held byte and clears data-ready. A byte that arrives while data-ready is set pulses `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte has been received |
| rx_data | input | 8 | Received byte |
| brk_in | input | 1 | One-cycle strobe: a break condition has been received |
| rd_en | input | 1 | Host read strobe; pops one byte |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| char_tick | input | 1 | One pulse per character time |
| rd_data | output | 8 | Byte presented to the host (valid while rd_en is high) |
| count | output | 5 | Bytes held (0 or 1 when queued mode is off) |
| trig_hit | output | 1 | Count has reached the selected trigger level |
| data_ready | output | 1 | At least one byte is waiting |
| brk_flag | output | 1 | Break received and not yet read out |
| tmo_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | One-cycle pulse: an arriving byte was dropped or overwrote unread data |
| tx_flush | output | 1 | One-cycle pulse: the transmit queue must be emptied |
| ctl_q | output | 8 | Retained control register contents |

## Verification
The bench fills the queue to 16 and pushes one more byte. A design with an off-by-one full test would overwrite the oldest byte, which shows up in the read-back order. It also drains the queue across the pointer wrap, so a pointer that wraps at the wrong point returns stale bytes.

The timeout is probed on the 3rd and the 4th tick, and again after a read that leaves one byte. It is probed once more after a read that empties the queue, where a design that ignores the fill state would raise a spurious timeout.

A repeated control write tests the equality rule, because a design that acts on every write would flush live data. A bit-0 toggle with the flush bits at 0 tests the forced flush, because a design that skips it would keep stale holding-register data.

// File: rtl/rxq_pkg.sv
// Package: shared helpers for the receive byte queue.
// Assumes the control register layout used by rx_fifo_ctl (bits 7:6 = level).
package rxq_pkg;

    // Map the 2-bit trigger selector to a byte count.
    function automatic logic [4:0] trig_bytes(input logic [1:0] sel);
        logic [4:0] n;
        case (sel)
            2'b00:   n = 5'd1;
            2'b01:   n = 5'd4;
            2'b10:   n = 5'd8;
            default: n = 5'd14;
        endcase
        return n;
    endfunction

    // Bits of the control register that are retained after a write.
    localparam logic [7:0] CTL_KEEP_MASK = 8'hC9;

endpackage

// File: rtl/rxq_ctl_decode.sv
// Module: decodes a control-register write into load and flush actions.
// Assumes ctl_q is the currently retained value; purely combinational.
module rxq_ctl_decode (
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    input  logic [7:0] ctl_q,
    output logic       ctl_ld,
    output logic [7:0] ctl_d,
    output logic       rx_clr,
    output logic       tx_clr
);
    import rxq_pkg::*;

    logic toggled;

    // Decide whether the write acts and which flushes it causes.
    always_comb begin
        ctl_ld  = ctl_wr && (ctl_wdata != ctl_q);
        toggled = ctl_wdata[0] ^ ctl_q[0];
        ctl_d   = ctl_wdata & CTL_KEEP_MASK;
        rx_clr  = ctl_ld && (ctl_wdata[1] || toggled);
        tx_clr  = ctl_ld && (ctl_wdata[2] || toggled);
    end
endmodule

// File: rtl/rxq_store.sv
// Module: circular byte store with head/tail pointers and a fill count.
// Assumes push/pop are already gated by mode; clr overrides both.
module rxq_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] fill,
    output logic          empty,
    output logic          pushed,
    output logic          popped,
    output logic          dropped
);
    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full;

    // Flags and accepted-operation decode.
    always_comb begin
        empty   = (fill == '0);
        full    = (fill == CW'(DEPTH));
        popped  = pop && !empty && !clr;
        pushed  = push && (!full || popped) && !clr;
        dropped = push && !pushed && !clr;
        dout    = empty ? '0 : mem[rd_ptr];
    end

    // Write the accepted byte into storage.
    always_ff @(posedge clk) begin
        if (pushed) mem[wr_ptr] <= din;
    end

    // Pointer and count bookkeeping with wrap at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (pushed) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + PW'(1);
            if (popped) rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + PW'(1);
            if (pushed && !popped)      fill <= fill + CW'(1);
            else if (popped && !pushed) fill <= fill - CW'(1);
        end
    end
endmodule

// File: rtl/rxq_timeout.sv
// Module: idle watchdog counting character ticks since the last restart.
// Assumes restart has priority over a tick in the same cycle.
module rxq_timeout #(
    parameter int TMO_CHARS = 4,
    localparam int TW       = $clog2(TMO_CHARS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cancel,
    input  logic restart,
    input  logic tick,
    input  logic holding,
    input  logic ack,
    output logic pend
);
    logic          armed;
    logic [TW-1:0] ticks;

    // Arm, count and expire; pending only if data is still held.
    always_ff @(posedge clk) begin
        if (!rst_n || cancel) begin
            armed <= 1'b0;
            ticks <= '0;
            pend  <= 1'b0;
        end else begin
            if (ack) pend <= 1'b0;
            if (restart) begin
                armed <= 1'b1;
                ticks <= '0;
            end else if (tick && armed) begin
                if (ticks == TW'(TMO_CHARS - 1)) begin
                    armed <= 1'b0;
                    ticks <= '0;
                    if (holding && !ack) pend <= 1'b1;
                end else begin
                    ticks <= ticks + TW'(1);
                end
            end
        end
    end
endmodule

// File: rtl/rx_fifo_ctl.sv
// Module: receive byte queue with trigger level, character timeout,
// break flag and a single-register fallback when queued mode is off.
// Assumes one strobe per received byte and one host read per rd_en cycle;
// a control write that flushes wins over a push or read in the same cycle.
module rx_fifo_ctl #(
    parameter int DEPTH     = 16,
    parameter int DW        = 8,
    parameter int TMO_CHARS = 4,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_data,
    input  logic          brk_in,
    input  logic          rd_en,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    input  logic          char_tick,
    output logic [DW-1:0] rd_data,
    output logic [CW-1:0] count,
    output logic          trig_hit,
    output logic          data_ready,
    output logic          brk_flag,
    output logic          tmo_pend,
    output logic          overrun,
    output logic          tx_flush,
    output logic [7:0]    ctl_q
);
    import rxq_pkg::*;

    logic          ctl_ld, rx_clr, tx_clr;
    logic [7:0]    ctl_d;
    logic          queued, push_any;
    logic [DW-1:0] din;
    logic [DW-1:0] q_dout, hold_q;
    logic [CW-1:0] q_fill;
    logic          q_empty, q_pushed, q_popped, q_dropped;
    logic          hold_rdy;
    logic [CW-1:0] level;

    rxq_ctl_decode u_dec (
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_q     (ctl_q),
        .ctl_ld    (ctl_ld),
        .ctl_d     (ctl_d),
        .rx_clr    (rx_clr),
        .tx_clr    (tx_clr)
    );

    // Mode and input merging: a break enters as a zero byte.
    always_comb begin
        queued   = ctl_q[0];
        push_any = rx_valid || brk_in;
        din      = brk_in ? '0 : rx_data;
        level    = CW'(trig_bytes(ctl_q[7:6]));
    end

    rxq_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (rx_clr),
        .push    (queued && push_any),
        .pop     (queued && rd_en),
        .din     (din),
        .dout    (q_dout),
        .fill    (q_fill),
        .empty   (q_empty),
        .pushed  (q_pushed),
        .popped  (q_popped),
        .dropped (q_dropped)
    );

    rxq_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk     (clk),
        .rst_n   (rst_n),
        .cancel  (rx_clr),
        .restart (q_pushed || (q_popped && (q_fill > CW'(1)))),
        .tick    (char_tick),
        .holding (!q_empty),
        .ack     (queued && rd_en),
        .pend    (tmo_pend)
    );

    // Control register and transmit-flush pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= tx_clr;
            if (ctl_ld) ctl_q <= ctl_d;
        end
    end

    // Holding register used while queued mode is off.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) begin
            hold_q   <= '0;
            hold_rdy <= 1'b0;
        end else if (!queued) begin
            if (push_any) begin
                hold_q   <= din;
                hold_rdy <= 1'b1;
            end else if (rd_en) begin
                hold_rdy <= 1'b0;
            end
        end
    end

    // Break flag: set on break, cleared by the read that empties the data.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) begin
            brk_flag <= 1'b0;
        end else if (brk_in) begin
            brk_flag <= 1'b1;
        end else if (rd_en && (!queued || (q_fill <= CW'(1)))) begin
            brk_flag <= 1'b0;
        end
    end

    // Overrun pulse for a dropped byte or an overwritten holding byte.
    always_ff @(posedge clk) begin
        if (!rst_n || rx_clr) overrun <= 1'b0;
        else overrun <= queued ? q_dropped : (push_any && hold_rdy && !rd_en);
    end

    // Host-facing view selected by mode.
    always_comb begin
        rd_data    = queued ? q_dout : hold_q;
        count      = queued ? q_fill : CW'(hold_rdy);
        data_ready = queued ? !q_empty : hold_rdy;
        trig_hit   = queued ? (q_fill >= level) : hold_rdy;
    end
endmodule

// File: rtl/rx_fifo_ctl_chk.sv
// Module: property checker for rx_fifo_ctl, attached by bind below.
// Assumes default DEPTH matches the bound instance parameter.
module rx_fifo_ctl_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          brk_in,
    input logic          rd_en,
    input logic          ctl_wr,
    input logic [7:0]    ctl_wdata,
    input logic [DW-1:0] rd_data,
    input logic [CW-1:0] count,
    input logic          data_ready,
    input logic          tmo_pend,
    input logic          overrun,
    input logic          tx_flush,
    input logic [7:0]    ctl_q
);
    // R2: the count never exceeds the depth.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R3: in queued mode an overrun only follows a full queue.
    a_r3_ovr_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && $past(ctl_q[0])) |-> ($past(count) == CW'(DEPTH)));

    // R4: an empty read returns zero.
    a_r4_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctl_q[0] && count == '0) |-> (rd_data == '0));

    // R4: an empty read with no arrival keeps the count at zero.
    a_r4_empty_read_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctl_q[0] && count == '0 && !rx_valid && !brk_in && !ctl_wr)
        |=> (count == '0));

    // R6: a write equal to the current contents changes nothing.
    a_r6_same_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_wdata == ctl_q) |=> ($stable(ctl_q) && !tx_flush));

    // R8: toggling the enable bit flushes both queues.
    a_r8_toggle_flush: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && (ctl_wdata[0] != ctl_q[0])) |=> (count == '0 && tx_flush && !data_ready));

    // R9: a pending timeout implies held data.
    a_r9_pend_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pend |-> (count != '0));

    // R10: a queued-mode read clears the pending timeout.
    a_r10_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && ctl_q[0]) |=> !tmo_pend);
endmodule

bind rx_fifo_ctl rx_fifo_ctl_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .brk_in     (brk_in),
    .rd_en      (rd_en),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (ctl_wdata),
    .rd_data    (rd_data),
    .count      (count),
    .data_ready (data_ready),
    .tmo_pend   (tmo_pend),
    .overrun    (overrun),
    .tx_flush   (tx_flush),
    .ctl_q      (ctl_q)
);

// File: tb/rx_fifo_ctl_test.sv
// Bench: directed scenarios for rx_fifo_ctl, one task per scenario.
module rx_fifo_ctl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       brk_in = 1'b0;
    logic       rd_en = 1'b0;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic       char_tick = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] count;
    logic       trig_hit, data_ready, brk_flag, tmo_pend, overrun, tx_flush;
    logic [7:0] ctl_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    rx_fifo_ctl uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .brk_in(brk_in), .rd_en(rd_en), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .char_tick(char_tick), .rd_data(rd_data), .count(count),
        .trig_hit(trig_hit), .data_ready(data_ready), .brk_flag(brk_flag),
        .tmo_pend(tmo_pend), .overrun(overrun), .tx_flush(tx_flush), .ctl_q(ctl_q)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_data = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic send_break();
        @(negedge clk); brk_in = 1'b1;
        @(negedge clk); brk_in = 1'b0;
    endtask

    task automatic pull(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1;
        #1 b = rd_data;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); char_tick = 1'b1;
            @(negedge clk); char_tick = 1'b0;
        end
    endtask

    task automatic t_reset();
        chk("R1 ctl_q", ctl_q, 8'h00);
        chk("R1 count", count, 0);
        chk("R1 flags", {data_ready, trig_hit, brk_flag, tmo_pend, overrun, tx_flush}, 6'b0);
    endtask

    task automatic t_holding();
        logic [7:0] b;
        push(8'hA5);
        chk("R12 ready", {data_ready, count}, {1'b1, 5'd1});
        push(8'h3C);
        chk("R12 overwrite overrun", overrun, 1'b1);
        pull(b);
        chk("R12 read value", b, 8'h3C);
        chk("R12 ready cleared", {data_ready, count}, 6'd0);
        push(8'h11);
        wr_ctl(8'h01);
        chk("R8 enable forces flush", {tx_flush, data_ready, count}, {1'b1, 1'b0, 5'd0});
        chk("R6 ctl kept", ctl_q, 8'h01);
    endtask

    task automatic t_order();
        logic [7:0] b;
        for (int i = 0; i < 16; i++) push(8'(i * 7 + 1));
        chk("R2 full count", count, 16);
        push(8'hEE);
        chk("R3 overrun pulse", overrun, 1'b1);
        chk("R3 count stays", count, 16);
        for (int i = 0; i < 16; i++) begin
            pull(b);
            chk("R2 order", b, 8'(i * 7 + 1));
        end
        pull(b);
        chk("R4 empty read zero", b, 0);
        chk("R4 empty count", count, 0);
        for (int r = 0; r < 2; r++) begin
            for (int i = 0; i < 10; i++) push(8'(8'h40 + r * 16 + i));
            for (int i = 0; i < 10; i++) begin
                pull(b);
                chk("R2 wrap order", b, 8'(8'h40 + r * 16 + i));
            end
        end
    endtask

    task automatic t_trigger();
        int lv [4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            wr_ctl({2'(s), 6'b000011});
            chk("R5 cleared", count, 0);
            for (int i = 0; i < lv[s] - 1; i++) push(8'(i));
            chk("R5 below level", trig_hit, (lv[s] == 1) ? 1'b0 : 1'b0);
            push(8'hFF);
            chk("R5 at level", trig_hit, 1'b1);
        end
    endtask

    task automatic t_control();
        wr_ctl(8'h03);
        wr_ctl(8'hFF);
        chk("R6 mask", ctl_q, 8'hC9);
        chk("R7 tx flush", tx_flush, 1'b1);
        push(8'h01); push(8'h02);
        wr_ctl(8'hC9);
        chk("R6 equal write keeps data", count, 2);
        chk("R6 equal write no flush", tx_flush, 1'b0);
        wr_ctl(8'hCD);
        chk("R7 tx only keeps rx", {tx_flush, count}, {1'b1, 5'd2});
        wr_ctl(8'hCB);
        chk("R7 rx clear", {count, data_ready}, 6'd0);
    endtask

    task automatic t_timeout();
        logic [7:0] b;
        wr_ctl(8'h03);
        push(8'h21); push(8'h22);
        ticks(3);
        chk("R9 not yet", tmo_pend, 1'b0);
        ticks(1);
        chk("R9 fourth tick", tmo_pend, 1'b1);
        pull(b);
        chk("R10 read clears", tmo_pend, 1'b0);
        ticks(3);
        chk("R9 restart by read", tmo_pend, 1'b0);
        ticks(1);
        chk("R9 expires again", tmo_pend, 1'b1);
        pull(b);
        ticks(4);
        chk("R9 empty no pend", tmo_pend, 1'b0);
        push(8'h33);
        ticks(4);
        chk("R9 set before clear", tmo_pend, 1'b1);
        wr_ctl(8'h03);
        chk("R7 clear cancels timeout", {tmo_pend, count}, 6'd0);
    endtask

    task automatic t_break();
        logic [7:0] b;
        send_break();
        chk("R11 break set", {brk_flag, data_ready, count}, {1'b1, 1'b1, 5'd1});
        pull(b);
        chk("R11 break byte", b, 0);
        chk("R11 cleared on empty", {brk_flag, data_ready}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_holding();
        t_order();
        t_trigger();
        t_control();
        t_timeout();
        t_break();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule